// File: doc/BRIEF.md
# Consecutive-Cycle Fault Qualification Filter

This block sits between two digitized protection comparators of a switching converter and the logic that stops the power switch. It watches an output-overvoltage comparator and a second-level (high) overcurrent comparator. It requests a shutdown only when a fault repeats over consecutive switching cycles, so that a single noisy event does not stop the converter.

The overvoltage comparator is examined once per off-period. Its sample window opens a programmable strobe delay after turn-off, which keeps the ringing that follows turn-off out of the result. Sampled hits are counted per oscillator cycle, and any cycle with no hit clears the count. The overcurrent comparator counts only while the switch conducts. A first overcurrent cycle puts the filter into a warning state. A second consecutive one stops the switch at once. A cycle without overcurrent returns the filter to idle.

A trip sets a latched shutdown request together with a sticky code that tells an external restart supervisor which fault fired. Both hold until the supply-undervoltage input asserts.

Top module: `fault_qual_filter`

## Requirements
- R1: After reset, `shut_req` is 0 and `fault_code` is 2'b00 (none).
- R2: `ov_cmp` is ignored while `gate_on` is high, and also during the first STROBE_DLY clocks of each off-period. A high level there adds no hit.
- R3: `ov_cmp` is sampled only during SAMPLE_WIN clocks, starting STROBE_DLY clocks after turn-off. Any number of high samples in one oscillator cycle counts as a single hit.
- R4: The overvoltage hit count clears at every `cycle_tick` that ends a cycle with no hit.
- R5: At the `cycle_tick` that ends the OV_TRIP-th consecutive cycle with a hit, `shut_req` goes high on the next clock and `fault_code` becomes 2'b01 (overvoltage).
- R6: A single cycle with `oc_cmp` high while `gate_on` is high enters the warning state without requesting shutdown.
- R7: A cycle without overcurrent that follows a warning cycle returns the filter to idle. A later isolated overcurrent cycle again only warns.
- R8: Overcurrent in OC_TRIP consecutive cycles sets `shut_req` on the clock after the first overcurrent sample of the final cycle, with `fault_code` 2'b10 (overcurrent).
- R9: Once set, `shut_req` stays high until `uvlo` is asserted. Asserting `uvlo` clears `shut_req`, the code and both filters.
- R10: When both faults qualify on the same clock, the code reports overcurrent (2'b10).
- R11: While `shut_req` is high, `fault_code` does not change, whatever the comparator inputs do.
- R12: When the switch turns back on before the strobe delay has elapsed, no overvoltage sample is taken in that off-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | One-clock pulse at the start of each oscillator cycle |
| gate_on | input | 1 | High while the power switch conducts |
| ov_cmp | input | 1 | Digitized output-overvoltage comparator |
| oc_cmp | input | 1 | Digitized second-level overcurrent comparator |
| uvlo | input | 1 | Supply undervoltage; clears the latch and the filters |
| shut_req | output | 1 | Latched shutdown request |
| fault_code | output | 2 | 00 none, 01 overvoltage, 10 overcurrent; sticky while latched |

## Verification
The embedded assertions check several rules on every cycle: the latch holds until undervoltage, the code is stable and non-zero while latched, and undervoltage clears both outputs. They also check that an overvoltage trip follows an oscillator tick, that an overcurrent trip follows a live overcurrent sample with the switch on, that a hit is recorded only from an off-period sample, and that the hit count moves upward only at a tick.

The bench scenarios cover the cycle-level behaviour. These include the clear-on-a-quiet-cycle rule, the early and aborted off-periods that must be ignored, multiple samples in one window counting once, the warning-then-idle path, and the same-clock priority of overcurrent over overvoltage. Randomly mixed cycles are compared against a cycle-level reference model.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_OV   = 2'b01,
    FC_OC   = 2'b10
  } fault_e;
endpackage

// File: rtl/ov_strobe_filter.sv
module ov_strobe_filter #(
  parameter int STROBE_DLY = 500,
  parameter int SAMPLE_WIN = 8,
  parameter int OV_TRIP    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cycle_tick,
  input  logic gate_on,
  input  logic ov_cmp,
  output logic ov_trip
);
  localparam int WIN_END = STROBE_DLY + SAMPLE_WIN;
  localparam int TW      = $clog2(WIN_END + 1);
  localparam int CW      = $clog2(OV_TRIP + 1);

  logic [TW-1:0] off_tmr;
  logic [CW-1:0] hits;
  logic          hit_seen;
  logic          win_open;
  logic          sample;
  logic          hit_any;

  assign win_open = !gate_on && (off_tmr >= TW'(STROBE_DLY)) && (off_tmr < TW'(WIN_END));
  assign sample   = win_open && ov_cmp;
  assign hit_any  = hit_seen || sample;
  assign ov_trip  = cycle_tick && hit_any && (hits == CW'(OV_TRIP - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      off_tmr  <= '0;
      hits     <= '0;
      hit_seen <= 1'b0;
    end else begin
      if (gate_on)
        off_tmr <= '0;
      else if (off_tmr != TW'(WIN_END))
        off_tmr <= off_tmr + 1'b1;

      if (cycle_tick) begin
        hit_seen <= 1'b0;
        if (hit_any) begin
          if (hits != CW'(OV_TRIP)) hits <= hits + 1'b1;
        end else begin
          hits <= '0;
        end
      end else begin
        hit_seen <= hit_any;
      end
    end
  end

  // R2: a recorded hit always comes from a sample taken with the switch off
  p_hit_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_seen) |-> $past(!gate_on));

  // R3: the count advances only at an oscillator tick, once per cycle
  p_count_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(hits) && hits != '0) |-> $past(cycle_tick));
endmodule

// File: rtl/oc_warn_filter.sv
module oc_warn_filter #(
  parameter int OC_TRIP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cycle_tick,
  input  logic gate_on,
  input  logic oc_cmp,
  output logic oc_trip
);
  localparam int CW = (OC_TRIP > 2) ? $clog2(OC_TRIP) : 1;

  logic [CW-1:0] run;
  logic [CW-1:0] run_eff;
  logic          seen;
  logic          oc_now;

  assign oc_now = gate_on && oc_cmp;

  always_comb begin
    run_eff = run;
    if (cycle_tick) begin
      if (seen)
        run_eff = (run == CW'(OC_TRIP - 1)) ? run : run + 1'b1;
      else
        run_eff = '0;
    end
  end

  assign oc_trip = oc_now && (run_eff == CW'(OC_TRIP - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run  <= '0;
      seen <= 1'b0;
    end else begin
      run  <= run_eff;
      seen <= cycle_tick ? oc_now : (seen || oc_now);
    end
  end

  // R6: no trip without an earlier overcurrent cycle in the run
  p_warn_first_r6: assert property (@(posedge clk) disable iff (rst)
    oc_trip |-> (run != '0 || (cycle_tick && seen)));
endmodule

// File: rtl/trip_latch.sv
module trip_latch
  import fq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       uvlo,
  input  logic       ov_trip,
  input  logic       oc_trip,
  output logic       shut_req,
  output logic [1:0] fault_code
);
  fault_e code_q;

  always_ff @(posedge clk) begin
    if (rst || uvlo) begin
      shut_req <= 1'b0;
      code_q   <= FC_NONE;
    end else if (!shut_req) begin
      if (oc_trip) begin
        shut_req <= 1'b1;
        code_q   <= FC_OC;
      end else if (ov_trip) begin
        shut_req <= 1'b1;
        code_q   <= FC_OV;
      end
    end
  end

  assign fault_code = code_q;

  // R9: latch holds until undervoltage
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (shut_req && !uvlo) |=> shut_req);
  // R9: undervoltage clears request and code
  p_uvlo_clear_r9: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (!shut_req && fault_code == FC_NONE));
  // R11: code frozen while latched
  p_code_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (shut_req && !uvlo) |=> $stable(fault_code));
  // R5: a latched request always carries a fault type
  p_code_valid_r5: assert property (@(posedge clk) disable iff (rst)
    shut_req |-> (fault_code == FC_OV || fault_code == FC_OC));
endmodule

// File: rtl/fault_qual_filter.sv
module fault_qual_filter
  import fq_pkg::*;
#(
  parameter int STROBE_DLY = 500,
  parameter int SAMPLE_WIN = 8,
  parameter int OV_TRIP    = 4,
  parameter int OC_TRIP    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycle_tick,
  input  logic       gate_on,
  input  logic       ov_cmp,
  input  logic       oc_cmp,
  input  logic       uvlo,
  output logic       shut_req,
  output logic [1:0] fault_code
);
  logic ov_trip;
  logic oc_trip;
  logic filt_clr;

  assign filt_clr = uvlo || shut_req;

  ov_strobe_filter #(
    .STROBE_DLY (STROBE_DLY),
    .SAMPLE_WIN (SAMPLE_WIN),
    .OV_TRIP    (OV_TRIP)
  ) u_ov (
    .clk        (clk),
    .rst        (rst),
    .clr        (filt_clr),
    .cycle_tick (cycle_tick),
    .gate_on    (gate_on),
    .ov_cmp     (ov_cmp),
    .ov_trip    (ov_trip)
  );

  oc_warn_filter #(
    .OC_TRIP (OC_TRIP)
  ) u_oc (
    .clk        (clk),
    .rst        (rst),
    .clr        (filt_clr),
    .cycle_tick (cycle_tick),
    .gate_on    (gate_on),
    .oc_cmp     (oc_cmp),
    .oc_trip    (oc_trip)
  );

  trip_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .uvlo       (uvlo),
    .ov_trip    (ov_trip),
    .oc_trip    (oc_trip),
    .shut_req   (shut_req),
    .fault_code (fault_code)
  );

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!shut_req && fault_code == FC_NONE));
  // R5: overvoltage trips only on an oscillator tick
  p_ov_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(shut_req) && fault_code == FC_OV) |-> $past(cycle_tick));
  // R8: overcurrent trip follows a live sample with the switch on
  p_oc_immediate_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(shut_req) && fault_code == FC_OC) |-> $past(gate_on && oc_cmp));
endmodule

// File: tb/sim_fault_qual_filter.sv
module sim_fault_qual_filter;
  localparam int S   = 20;
  localparam int W   = 6;
  localparam int OVT = 4;
  localparam int P   = 64;
  localparam int ON  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycle_tick = 1'b0, gate_on = 1'b0, ov_cmp = 1'b0, oc_cmp = 1'b0, uvlo = 1'b0;
  logic shut_req;
  logic [1:0] fault_code;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_ovc = 0, m_occ = 0;
  bit m_prev_hit = 0, m_prev_oc = 0, m_shut = 0;
  logic [1:0] m_code = 2'b00;

  always #2 clk = ~clk;

  fault_qual_filter #(.STROBE_DLY(S), .SAMPLE_WIN(W), .OV_TRIP(OVT), .OC_TRIP(2)) u0 (
    .clk(clk), .rst(rst), .cycle_tick(cycle_tick), .gate_on(gate_on),
    .ov_cmp(ov_cmp), .oc_cmp(oc_cmp), .uvlo(uvlo),
    .shut_req(shut_req), .fault_code(fault_code));

  task automatic check(input string req, input logic sh_exp, input logic [1:0] code_exp);
    n_chk++;
    if (shut_req !== sh_exp || fault_code !== code_exp) begin
      n_fail++;
      $display("FAIL %s: shut_req=%b fault_code=%b expected shut_req=%b fault_code=%b",
               req, shut_req, fault_code, sh_exp, code_exp);
    end
  endtask

  function automatic bit hit_of(input int ovm, input int on_len);
    if (ovm == 1) return (P - on_len) > S;
    if (ovm == 3) return (P - on_len) > S + 4;
    return 1'b0;
  endfunction

  // ovm: 0 quiet, 1 high over whole off-period, 2 high only while on and before strobe, 3 pulses in window
  task automatic run_cycle(input int ovm, input bit oc, input int on_len, input string req);
    bit ovt, oct;
    if (!m_shut) begin
      ovt = 0; oct = 0;
      if (m_prev_hit) begin m_ovc++; if (m_ovc == OVT) ovt = 1; end
      else m_ovc = 0;
      m_occ = m_prev_oc ? 1 : 0;
      if (oc && on_len > 0 && m_occ >= 1) oct = 1;
      if (oct) begin m_shut = 1; m_code = 2'b10; end
      else if (ovt) begin m_shut = 1; m_code = 2'b01; end
    end
    m_prev_hit = hit_of(ovm, on_len);
    m_prev_oc  = oc && on_len > 0;
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      cycle_tick = (c == 0);
      gate_on    = (c < on_len);
      oc_cmp     = oc && (c < on_len);
      case (ovm)
        1: ov_cmp = (c >= on_len);
        2: ov_cmp = (c < on_len + S - 4);
        3: ov_cmp = (c == on_len + S) || (c == on_len + S + 2) || (c == on_len + S + 4);
        default: ov_cmp = 1'b0;
      endcase
    end
    @(posedge clk); #1;
    check(req, m_shut, m_code);
  endtask

  task automatic do_uvlo(input string req);
    @(negedge clk);
    uvlo = 1; cycle_tick = 0; gate_on = 0; ov_cmp = 0; oc_cmp = 0;
    repeat (2) @(negedge clk);
    uvlo = 0;
    @(posedge clk); #1;
    m_ovc = 0; m_occ = 0; m_prev_hit = 0; m_prev_oc = 0; m_shut = 0; m_code = 2'b00;
    check(req, 1'b0, 2'b00);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    check("R1 reset", 1'b0, 2'b00);

    // R4: a quiet cycle clears the run
    repeat (3) run_cycle(1, 0, ON, "R4 hits");
    run_cycle(0, 0, ON, "R4 clear");
    repeat (3) run_cycle(1, 0, ON, "R4 hits again");
    run_cycle(0, 0, ON, "R4 no trip after cleared run");
    // R5: four consecutive hits
    repeat (4) run_cycle(1, 0, ON, "R5 hit");
    run_cycle(0, 0, ON, "R5 overvoltage trip");
    repeat (3) run_cycle(0, 0, ON, "R9 hold");
    do_uvlo("R9 uvlo clear");

    // R2: level high during on-time and before strobe is ignored
    repeat (5) run_cycle(2, 0, ON, "R2 early ignored");
    run_cycle(0, 0, ON, "R2 no trip");
    // R12: off-period shorter than strobe delay
    repeat (5) run_cycle(1, 0, P - 8, "R12 aborted window");
    run_cycle(0, 0, ON, "R12 no trip");
    // R3: several samples in one window count once
    repeat (3) run_cycle(3, 0, ON, "R3 pulses");
    run_cycle(3, 0, ON, "R3 fourth cycle");
    run_cycle(0, 0, ON, "R3 trip on fourth cycle");
    do_uvlo("R9 uvlo clear 2");

    // R6/R7: isolated overcurrent only warns
    run_cycle(0, 1, ON, "R6 warn no trip");
    run_cycle(0, 0, ON, "R7 back to idle");
    run_cycle(0, 1, ON, "R7 warn again");
    run_cycle(0, 0, ON, "R7 idle again");
    // R8: two consecutive overcurrent cycles
    run_cycle(0, 1, ON, "R8 first");
    run_cycle(0, 1, ON, "R8 trip");
    // R11: code sticky
    repeat (5) run_cycle(1, 0, ON, "R11 code sticky");
    do_uvlo("R9 uvlo clear 3");

    // R10: both qualify on the same tick
    repeat (3) run_cycle(1, 0, ON, "R10 build");
    run_cycle(1, 1, ON, "R10 warn and fourth hit");
    run_cycle(0, 1, ON, "R10 overcurrent wins");
    do_uvlo("R9 uvlo clear 4");

    for (int i = 0; i < 300; i++) begin
      int r, ovm;
      bit oc;
      r = $urandom_range(0, 9);
      ovm = (r < 6) ? 1 : (r < 8 ? 2 : 0);
      oc = ($urandom_range(0, 9) < 2);
      if (m_shut && $urandom_range(0, 3) == 0)
        do_uvlo("R9 random uvlo");
      else
        run_cycle(ovm, oc, ON, "R5 R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule